// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the per-channel transfer datapath of a DMA controller. The host loads a starting address offset and a transfer count, and each transfer-done strobe then advances the address and retires one count unit. The address output is a 24-bit physical byte address. It is built from a fixed page value and the current 16-bit address offset. Only the offset moves, so a run of transfers stays inside one window and wraps within it. The window is 64K bytes on a byte-wide channel and 128K bytes on a 16-bit word channel.

The count is held as "transfers minus one". The channel signals terminal count on the transfer that finds the count at zero. At that point it either reloads its starting address and count (auto-initialize), or masks itself so that later strobes are ignored until the next load. The host-visible residue is the count plus one, taken modulo 2^16, so a channel that has finished reads back zero. The channel width is fixed by a parameter or selected at run time.

Top module: `xfer_addr_engine`

## Requirements
- R1: With `word_sel`=0, `phys_addr` equals {`page`[7:0], `cur_addr`[15:0]}.
- R2: With `word_sel`=1, `phys_addr` equals {`page`[7:1], `cur_addr`[15:0], 1'b0}. `page` bit 0 has no effect and `phys_addr` bit 0 is always 0.
- R3: Each accepted transfer steps `cur_addr` by one modulo 2^16. The step is up when `dir_down`=0 and down when `dir_down`=1. The page part of `phys_addr` never changes because of a transfer.
- R4: Each accepted transfer decrements `cur_count` by one. A loaded count N produces exactly N+1 accepted transfers before terminal count, including the terminal one. A count of 0 gives a single transfer.
- R5: `tc_pulse` is high for exactly the one cycle after the clock edge that accepts a transfer with `cur_count`=0, and is low at all other times.
- R6: With `auto_init`=1, the terminal transfer reloads `cur_addr` and `cur_count` from the values last loaded, and `masked` stays 0.
- R7: With `auto_init`=0, the terminal transfer sets `masked` to 1 and leaves `cur_count` at 0xFFFF. While `masked`=1, `xfer_done` has no effect on `cur_addr`, `cur_count` or `tc_pulse`.
- R8: `residue` equals (`cur_count`+1) mod 2^16, so it reads 0 after a non-auto-initialize run completes.
- R9: A `load` strobe writes both the starting and current address and count, and clears `masked`. It takes priority over an `xfer_done` in the same cycle, and that transfer is dropped.
- R10: After reset, `cur_addr`=0, `cur_count`=0, `tc_pulse`=0 and `masked`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load starting and current address and count; unmask |
| load_addr | input | 16 | Address offset to load |
| load_count | input | 16 | Transfers minus one to load |
| page | input | 8 | Page value forming the upper physical address bits |
| word_sel | input | 1 | 1 = 16-bit word channel, 0 = byte channel |
| dir_down | input | 1 | 1 = address decrements, 0 = increments |
| auto_init | input | 1 | Reload at terminal count instead of masking |
| xfer_done | input | 1 | One transfer has completed |
| phys_addr | output | 24 | Physical byte address of the current transfer |
| cur_addr | output | 16 | Current address offset |
| cur_count | output | 16 | Current count (transfers remaining minus one) |
| residue | output | 16 | Host-visible residue, count plus one mod 2^16 |
| tc_pulse | output | 1 | One-cycle terminal count pulse |
| masked | output | 1 | Channel masked; transfers ignored |

## Verification
The hardest situation to reach is a terminal transfer that coincides with the address offset wrapping at the edge of its window. The wrap must stay in the window and not carry into the page. In auto-initialize mode, the reload must win over the step on that same edge. The stimulus reaches this by loading offsets of 0xFFFE and 0x0001 with small counts, in both directions and both widths. A bench model then tracks every strobe across repeated reload cycles. A separate sweep covers all 256 page values in both widths, and a further case raises load and a transfer strobe together on a masked channel.

// File: rtl/xae_pkg.sv
package xae_pkg;
   // Which channel width variant the mapping logic is built for
   typedef enum logic [1:0] {
      KIND_BYTE    = 2'd0,
      KIND_WORD    = 2'd1,
      KIND_RUNTIME = 2'd2
   } chan_kind_e;
endpackage

// File: rtl/xae_addr_unit.sv
module xae_addr_unit #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              advance,
   input  logic              reload,
   input  logic              dir_down,
   output logic [ADDR_W-1:0] cur_addr
);
   logic [ADDR_W-1:0] start_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] stepped;

   // Offset arithmetic is confined to ADDR_W bits: it wraps, never carries into the page
   always_comb begin
      if (dir_down) stepped = cur_q - 1'b1;
      else          stepped = cur_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         cur_q   <= '0;
      end else if (load) begin
         start_q <= load_addr;
         cur_q   <= load_addr;
      end else if (reload) begin
         cur_q   <= start_q;
      end else if (advance) begin
         cur_q   <= stepped;
      end
   end

   assign cur_addr = cur_q;
endmodule

// File: rtl/xae_count_unit.sv
module xae_count_unit #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_count,
   input  logic             xfer_done,
   input  logic             auto_init,
   output logic             advance,
   output logic             reload,
   output logic [CNT_W-1:0] cur_count,
   output logic [CNT_W-1:0] residue,
   output logic             tc_pulse,
   output logic             masked
);
   logic [CNT_W-1:0] start_q;
   logic [CNT_W-1:0] cur_q;
   logic             mask_q;
   logic             tc_q;
   logic             at_end;

   assign at_end  = (cur_q == '0);
   // Load wins over a transfer in the same cycle; a masked channel accepts nothing
   assign advance = xfer_done && !mask_q && !load;
   assign reload  = advance && at_end && auto_init;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         cur_q   <= '0;
         mask_q  <= 1'b1;
         tc_q    <= 1'b0;
      end else begin
         tc_q <= advance && at_end;
         if (load) begin
            start_q <= load_count;
            cur_q   <= load_count;
            mask_q  <= 1'b0;
         end else if (advance) begin
            if (reload) cur_q <= start_q;
            else        cur_q <= cur_q - 1'b1;
            if (at_end && !auto_init) mask_q <= 1'b1;
         end
      end
   end

   assign cur_count = cur_q;
   assign residue   = cur_q + 1'b1;
   assign tc_pulse  = tc_q;
   assign masked    = mask_q;
endmodule

// File: rtl/xae_phys_map.sv
module xae_phys_map
   import xae_pkg::*;
#(
   parameter int         ADDR_W = 16,
   parameter int         PAGE_W = 8,
   parameter chan_kind_e KIND   = KIND_RUNTIME,
   localparam int        PHYS_W = PAGE_W + ADDR_W
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [ADDR_W-1:0] offset,
   input  logic              word_sel,
   output logic [PHYS_W-1:0] phys_addr
);
   logic              eff_word;
   logic [PHYS_W-1:0] byte_form;
   logic [PHYS_W-1:0] word_form;

   generate
      if (KIND == KIND_BYTE) begin : g_byte
         assign eff_word = word_sel & 1'b0;
      end else if (KIND == KIND_WORD) begin : g_word
         assign eff_word = word_sel | 1'b1;
      end else begin : g_runtime
         assign eff_word = word_sel;
      end
   endgenerate

   // Byte: page on top of the offset. Word: offset shifted up one, page LSB dropped.
   assign byte_form = {page, offset};
   assign word_form = {page[PAGE_W-1:1], offset, 1'b0};
   assign phys_addr = eff_word ? word_form : byte_form;
endmodule

// File: rtl/xfer_addr_engine.sv
module xfer_addr_engine
   import xae_pkg::*;
#(
   parameter int         ADDR_W = 16,
   parameter int         CNT_W  = 16,
   parameter int         PAGE_W = 8,
   parameter chan_kind_e KIND   = KIND_RUNTIME,
   localparam int        PHYS_W = PAGE_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [CNT_W-1:0]  load_count,
   input  logic [PAGE_W-1:0] page,
   input  logic              word_sel,
   input  logic              dir_down,
   input  logic              auto_init,
   input  logic              xfer_done,
   output logic [PHYS_W-1:0] phys_addr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_count,
   output logic [CNT_W-1:0]  residue,
   output logic              tc_pulse,
   output logic              masked
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("xfer_addr_engine: ADDR_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("xfer_addr_engine: CNT_W must be at least 1");
      end
      if (PAGE_W < 2) begin : g_bad_page
         $error("xfer_addr_engine: PAGE_W must be at least 2");
      end
   endgenerate

   logic advance;
   logic reload;

   xae_count_unit #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_count(load_count),
      .xfer_done (xfer_done),
      .auto_init (auto_init),
      .advance   (advance),
      .reload    (reload),
      .cur_count (cur_count),
      .residue   (residue),
      .tc_pulse  (tc_pulse),
      .masked    (masked)
   );

   xae_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_addr(load_addr),
      .advance  (advance),
      .reload   (reload),
      .dir_down (dir_down),
      .cur_addr (cur_addr)
   );

   xae_phys_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .KIND(KIND)) u_map (
      .page     (page),
      .offset   (cur_addr),
      .word_sel (word_sel),
      .phys_addr(phys_addr)
   );
endmodule

// File: rtl/xae_checker.sv
module xae_checker #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int PAGE_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     load,
   input logic                     word_sel,
   input logic                     dir_down,
   input logic                     auto_init,
   input logic                     xfer_done,
   input logic [PAGE_W+ADDR_W-1:0] phys_addr,
   input logic [ADDR_W-1:0]        cur_addr,
   input logic [CNT_W-1:0]         cur_count,
   input logic                     tc_pulse,
   input logic                     masked
);
   // R2: word channel never drives an odd byte address
   assert_word_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
      word_sel |-> (phys_addr[0] == 1'b0));

   // R3: increment step when not terminal and not reloading
   assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !masked && !load && !dir_down && cur_count != '0)
      |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

   // R3: decrement step
   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !masked && !load && dir_down && cur_count != '0)
      |=> (cur_addr == ADDR_W'($past(cur_addr) - 1'b1)));

   // R5: terminal pulse follows only an accepted transfer at count zero
   assert_tc_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !masked && !load && cur_count == '0) |=> tc_pulse);

   assert_tc_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tc_pulse |=> !tc_pulse);

   // R7: terminal transfer without auto-initialize masks the channel
   assert_self_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !masked && !load && cur_count == '0 && !auto_init) |=> masked);

   // R7: masked channel ignores transfer strobes
   assert_masked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (masked && !load) |=> ($stable(cur_addr) && $stable(cur_count) && !tc_pulse));

   // R9: load unmasks
   assert_load_unmask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !masked);
endmodule

bind xfer_addr_engine xae_checker #(
   .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)
) u_xae_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .load     (load),
   .word_sel (word_sel),
   .dir_down (dir_down),
   .auto_init(auto_init),
   .xfer_done(xfer_done),
   .phys_addr(phys_addr),
   .cur_addr (cur_addr),
   .cur_count(cur_count),
   .tc_pulse (tc_pulse),
   .masked   (masked)
);

// File: tb/test_xfer_addr_engine.sv
module test_xfer_addr_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [15:0] load_addr = '0;
   logic [15:0] load_count = '0;
   logic [7:0]  page = '0;
   logic        word_sel = 1'b0;
   logic        dir_down = 1'b0;
   logic        auto_init = 1'b0;
   logic        xfer_done = 1'b0;
   logic [23:0] phys_addr;
   logic [15:0] cur_addr;
   logic [15:0] cur_count;
   logic [15:0] residue;
   logic        tc_pulse;
   logic        masked;

   int checks = 0;
   int errors = 0;

   // Bench model state
   logic [15:0] m_addr, m_cnt, m_base_a, m_base_c;
   logic        m_mask, m_tc;

   always #2.5 clk = ~clk;

   xfer_addr_engine i_xfer_addr_engine (
      .clk(clk), .rst_n(rst_n), .load(load), .load_addr(load_addr),
      .load_count(load_count), .page(page), .word_sel(word_sel),
      .dir_down(dir_down), .auto_init(auto_init), .xfer_done(xfer_done),
      .phys_addr(phys_addr), .cur_addr(cur_addr), .cur_count(cur_count),
      .residue(residue), .tc_pulse(tc_pulse), .masked(masked)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_phys(input logic [7:0] pg, input logic [15:0] a, input logic w);
      if (w) return {pg[7:1], 1'b0, 16'h0} + {7'h0, a, 1'b0};
      return {pg, 16'h0} + {8'h0, a};
   endfunction

   task automatic check_all(input string tag);
      chk({tag, " R3 cur_addr"}, 32'(cur_addr), 32'(m_addr));
      chk({tag, " R4 cur_count"}, 32'(cur_count), 32'(m_cnt));
      chk({tag, " R5 tc_pulse"}, 32'(tc_pulse), 32'(m_tc));
      chk({tag, " R7 masked"}, 32'(masked), 32'(m_mask));
      chk({tag, " R8 residue"}, 32'(residue), 32'(16'(m_cnt + 16'd1)));
      chk({tag, " R1/R2 phys"}, 32'(phys_addr), 32'(exp_phys(page, m_addr, word_sel)));
   endtask

   task automatic do_load(input logic [15:0] a, input logic [15:0] c);
      @(negedge clk);
      load = 1'b1; load_addr = a; load_count = c;
      @(negedge clk);
      load = 1'b0;
      m_addr = a; m_cnt = c; m_base_a = a; m_base_c = c; m_mask = 1'b0; m_tc = 1'b0;
      check_all("load R9");
   endtask

   task automatic do_xfer();
      @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      m_tc = 1'b0;
      if (!m_mask) begin
         m_tc = (m_cnt == 16'd0);
         if (m_tc && auto_init) begin
            m_addr = m_base_a; m_cnt = m_base_c;       // R6
         end else begin
            m_addr = dir_down ? m_addr - 16'd1 : m_addr + 16'd1;
            m_cnt  = m_cnt - 16'd1;
            if (m_tc) m_mask = 1'b1;
         end
      end
      check_all("xfer R6");
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 cur_addr", 32'(cur_addr), 0);
      chk("R10 cur_count", 32'(cur_count), 0);
      chk("R10 tc_pulse", 32'(tc_pulse), 0);
      chk("R10 masked", 32'(masked), 1);
      m_addr = 0; m_cnt = 0; m_base_a = 0; m_base_c = 0; m_mask = 1; m_tc = 0;
      do_xfer();  // R7: ignored while masked from reset

      // R1, R2: full page sweep in both widths
      for (int w = 0; w < 2; w++) begin
         for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            word_sel = w[0]; page = p[7:0];
            #1;
            chk(w ? "R2 page sweep" : "R1 page sweep", 32'(phys_addr),
                32'(exp_phys(page, m_addr, word_sel)));
         end
      end

      // Near-exhaustive mode sweep over small counts and edge offsets (R3 R4 R5 R6 R7 R8)
      for (int w = 0; w < 2; w++) begin
         for (int d = 0; d < 2; d++) begin
            for (int ai = 0; ai < 2; ai++) begin
               for (int c = 0; c < 4; c++) begin
                  for (int s = 0; s < 3; s++) begin
                     logic [15:0] start;
                     start = (s == 0) ? 16'hFFFE : (s == 1) ? 16'h0001 : 16'h8000;
                     @(negedge clk);
                     word_sel = w[0]; dir_down = d[0]; auto_init = ai[0];
                     page = 8'hA5 ^ 8'(c * 17 + s);
                     do_load(start, 16'(c));
                     for (int k = 0; k < 2 * c + 4; k++) do_xfer();
                  end
               end
            end
         end
      end

      // R9: load and transfer together on a masked channel; load wins
      auto_init = 1'b0; dir_down = 1'b0;
      do_load(16'h1000, 16'd0);
      do_xfer();                       // terminal, masks
      chk("R7 masked after tc", 32'(masked), 1);
      chk("R8 residue zero", 32'(residue), 0);
      @(negedge clk);
      load = 1'b1; xfer_done = 1'b1; load_addr = 16'h2222; load_count = 16'd5;
      @(negedge clk);
      load = 1'b0; xfer_done = 1'b0;
      chk("R9 addr on collision", 32'(cur_addr), 32'h2222);
      chk("R9 count on collision", 32'(cur_count), 5);
      chk("R9 unmasked", 32'(masked), 0);
      chk("R9 no tc", 32'(tc_pulse), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule